// File: doc/BRIEF.md
# Periodic Bitstream Test Stimulus Generator

This block supports on-chip static testing of a one-bit oversampled converter. It holds a short one-bit pattern and plays it back over and over. The pattern is what a sigma-delta modulator would produce for one fixed analog level. Each played bit leaves the block on two outputs in the same cycle. The stimulus output feeds an external one-bit DAC or smoothing filter. The reference output gives the response analyser the ideal bit it expects back from the modulator under test. Because one register feeds both outputs, there is no second copy of the expected stream.

Software, or a test controller, first shifts the pattern in one bit per cycle while the block is idle. It then gives a start pulse. The pattern length is captured at start and stays fixed for the whole run, so the encoded level cannot change inside a test window. A clock enable sets the bit rate. A strobe marks every bit advance, and a separate pulse marks the last bit of each pass so the analyser can frame its windows.

A stop request ends the run only at a pass boundary, which leaves the register in its home rotation. A mode input steers either the played stimulus or the normal functional bit onto the modulator-drive output.

Top module: `bitstream_stim_gen`

## Requirements
- R1: After reset, busy, stim_out, ref_out, bit_valid and period_done are all 0 and the stored pattern is all zeros.
- R2: While idle, each cycle with load_en high writes load_bit into the pattern. The k-th bit of a burst (k counted from 0 at the first load_en cycle after load_en was low) is the k-th bit played in each pass. load_en low resets the write position to 0. load_en has no effect while busy.
- R3: In every cycle, ref_out equals stim_out. bit_valid is high exactly in cycles where busy and bit_ce are both high, and each such cycle consumes the bit on stim_out.
- R4: The len_m1 field gives the pattern length minus one: 0 means 1 bit and 63 means 64 bits (default size). It is sampled on the start pulse. Changes to len_m1 while busy have no effect on the running pass length.
- R5: After the last bit of a pass, the very next advance plays bit 0 again. There is no idle bit or gap cycle between passes.
- R6: period_done is high together with bit_valid on the last bit of every pass and is low at all other times.
- R7: In a busy cycle with bit_ce low there is no advance, and stim_out and ref_out keep the same bit as in the previous cycle.
- R8: A start pulse while idle makes busy high in the next cycle, and bit 0 is played first. A stop pulse while busy takes effect after the last bit of the current pass. busy falls in the cycle after that bit. A start pulse while busy is ignored.
- R9: When test_mode is 1, path_out equals stim_out. When test_mode is 0, path_out equals func_in.
- R10: While idle, stim_out, ref_out, bit_valid and period_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Serial pattern write enable (idle only) |
| load_bit | input | 1 | Serial pattern data bit |
| len_m1 | input | 6 | Pattern length minus one, sampled on start |
| start | input | 1 | Begin playback from bit 0 |
| stop | input | 1 | End playback at the next pass boundary |
| bit_ce | input | 1 | Bit-rate enable; one advance per high cycle |
| test_mode | input | 1 | 1 = drive stimulus, 0 = drive functional input |
| func_in | input | 1 | Normal functional bit for the modulator path |
| path_out | output | 1 | Selected bit toward the modulator path |
| stim_out | output | 1 | Stimulus bit toward the one-bit DAC/filter |
| ref_out | output | 1 | Ideal reference bit toward the response analyser |
| bit_valid | output | 1 | Strobe: current bit is consumed this cycle |
| period_done | output | 1 | Strobe: current bit is the last of its pass |
| busy | output | 1 | Playback is running |

## Verification
The bench uses four kinds of stimulus.
- An irregular 8-bit pattern with bit_ce held high. A mid-pass stop separates correct pass framing and stop-at-boundary from an off-by-one in the wrap point.
- A single-bit pattern (len_m1 = 0). This corner is where the last bit and bit 0 are the same position, so a missing period_done or a gap cycle shows up at once.
- A full 64-bit pattern paced by bit_ce every third cycle. During this run len_m1 changes, loads and restarts are attempted, and test_mode and func_in are toggled. These separate correct holding, length sampling and busy-time ignore rules from a design that leaks any of those inputs.
- A replay of the same 64-bit pattern without reloading. It shows that the stored bits survived both the run and the ignored load attempts.

// File: rtl/stim_pkg.sv
package stim_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   function automatic int unsigned len_bits(input int unsigned max_len);
      return (max_len < 2) ? 1 : $clog2(max_len);
   endfunction
endpackage

// File: rtl/stim_seq_ctrl.sv
module stim_seq_ctrl
   import stim_pkg::*;
#(
   parameter int unsigned LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             bit_ce,
   input  logic [LEN_W-1:0] len_m1,
   output logic             running,
   output logic [LEN_W-1:0] len_q,
   output logic             advance,
   output logic             wrap
);
   seq_state_e       state_q;
   logic [LEN_W-1:0] phase_q;
   logic             stop_pend_q;
   logic             last_bit;

   assign running  = (state_q == SEQ_RUN);
   assign advance  = running & bit_ce;
   assign last_bit = (phase_q == len_q);
   assign wrap     = advance & last_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= SEQ_IDLE;
         phase_q     <= '0;
         len_q       <= '0;
         stop_pend_q <= 1'b0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q     <= SEQ_RUN;
                  len_q       <= len_m1;
                  phase_q     <= '0;
                  stop_pend_q <= 1'b0;
               end
            end
            SEQ_RUN: begin
               if (stop) stop_pend_q <= 1'b1;
               if (advance) begin
                  if (last_bit) begin
                     phase_q <= '0;
                     if (stop_pend_q || stop) begin
                        state_q     <= SEQ_IDLE;
                        stop_pend_q <= 1'b0;
                     end
                  end else begin
                     phase_q <= phase_q + 1'b1;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/stim_pattern_store.sv
module stim_pattern_store #(
   parameter int unsigned MAX_LEN = 64,
   parameter int unsigned LEN_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             running,
   input  logic             advance,
   input  logic [LEN_W-1:0] len_q,
   input  logic             load_en,
   input  logic             load_bit,
   output logic             head_bit
);
   localparam logic [LEN_W-1:0] LAST_POS = LEN_W'(MAX_LEN - 1);

   logic [MAX_LEN-1:0] pat_q;
   logic [MAX_LEN-1:0] rot_next;
   logic [LEN_W-1:0]   wr_ptr_q;

   assign head_bit = pat_q[0];

   // Rotation confined to positions 0..len_q; higher cells hold.
   for (genvar i = 0; i < MAX_LEN; i++) begin : g_cell
      if (i == MAX_LEN - 1) begin : g_top
         assign rot_next[i] = (len_q == LEN_W'(i)) ? pat_q[0] : pat_q[i];
      end else begin : g_mid
         assign rot_next[i] = (len_q == LEN_W'(i)) ? pat_q[0]
                            : (LEN_W'(i) < len_q)  ? pat_q[i+1]
                            :                        pat_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pat_q    <= '0;
         wr_ptr_q <= '0;
      end else if (!running) begin
         if (load_en) begin
            pat_q[wr_ptr_q] <= load_bit;
            wr_ptr_q        <= (wr_ptr_q == LAST_POS) ? '0 : wr_ptr_q + 1'b1;
         end else begin
            wr_ptr_q <= '0;
         end
      end else begin
         wr_ptr_q <= '0;
         if (advance) pat_q <= rot_next;
      end
   end
endmodule

// File: rtl/stim_path_sel.sv
module stim_path_sel (
   input  logic test_mode,
   input  logic stim_bit,
   input  logic func_in,
   output logic path_out
);
   always_comb begin
      path_out = test_mode ? stim_bit : func_in;
   end
endmodule

// File: rtl/bitstream_stim_gen.sv
module bitstream_stim_gen
   import stim_pkg::*;
#(
   parameter int unsigned MAX_LEN = 64,
   parameter int unsigned LEN_W   = len_bits(MAX_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic             load_bit,
   input  logic [LEN_W-1:0] len_m1,
   input  logic             start,
   input  logic             stop,
   input  logic             bit_ce,
   input  logic             test_mode,
   input  logic             func_in,
   output logic             path_out,
   output logic             stim_out,
   output logic             ref_out,
   output logic             bit_valid,
   output logic             period_done,
   output logic             busy
);
   if (MAX_LEN < 2) begin : g_bad_len
      $error("MAX_LEN must be at least 2");
   end
   if ((1 << LEN_W) < MAX_LEN) begin : g_bad_w
      $error("LEN_W too narrow for MAX_LEN");
   end

   logic             running;
   logic             advance;
   logic             wrap;
   logic             head_bit;
   logic             played;
   logic [LEN_W-1:0] len_q;

   stim_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .stop    (stop),
      .bit_ce  (bit_ce),
      .len_m1  (len_m1),
      .running (running),
      .len_q   (len_q),
      .advance (advance),
      .wrap    (wrap)
   );

   stim_pattern_store #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .running  (running),
      .advance  (advance),
      .len_q    (len_q),
      .load_en  (load_en),
      .load_bit (load_bit),
      .head_bit (head_bit)
   );

   assign played      = running & head_bit;
   assign stim_out    = played;
   assign ref_out     = played;
   assign bit_valid   = advance;
   assign period_done = wrap;
   assign busy        = running;

   stim_path_sel u_sel (
      .test_mode (test_mode),
      .stim_bit  (played),
      .func_in   (func_in),
      .path_out  (path_out)
   );
endmodule

// File: rtl/stim_gen_checker.sv
module stim_gen_checker #(
   parameter int unsigned LEN_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             bit_ce,
   input logic             test_mode,
   input logic             func_in,
   input logic             path_out,
   input logic             stim_out,
   input logic             ref_out,
   input logic             bit_valid,
   input logic             period_done,
   input logic             busy,
   input logic [LEN_W-1:0] len_q
);
   logic [LEN_W:0] adv_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) adv_cnt <= '0;
      else if (bit_valid) adv_cnt <= period_done ? '0 : adv_cnt + 1'b1;
   end

   p_ref_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stim_out == ref_out);

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!stim_out && !bit_valid && !period_done));

   p_wrap_on_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      period_done |-> bit_valid);

   p_pass_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      period_done |-> adv_cnt == {1'b0, len_q});

   p_hold_no_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bit_ce) |=> (busy && $stable(stim_out)));

   p_stop_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !period_done) |=> busy);

   p_start_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   p_path_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      path_out == (test_mode ? stim_out : func_in));
endmodule

bind bitstream_stim_gen stim_gen_checker #(.LEN_W(LEN_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .bit_ce      (bit_ce),
   .test_mode   (test_mode),
   .func_in     (func_in),
   .path_out    (path_out),
   .stim_out    (stim_out),
   .ref_out     (ref_out),
   .bit_valid   (bit_valid),
   .period_done (period_done),
   .busy        (busy),
   .len_q       (len_q)
);

// File: tb/bitstream_stim_gen_tb.sv
`timescale 1ns/1ps
module bitstream_stim_gen_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_en = 1'b0, load_bit = 1'b0;
   logic [5:0] len_m1 = '0;
   logic       start = 1'b0, stop = 1'b0, bit_ce = 1'b1;
   logic       test_mode = 1'b1, func_in = 1'b0;
   logic       path_out, stim_out, ref_out, bit_valid, period_done, busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bitstream_stim_gen u_dut (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_bit(load_bit),
      .len_m1(len_m1), .start(start), .stop(stop), .bit_ce(bit_ce),
      .test_mode(test_mode), .func_in(func_in), .path_out(path_out),
      .stim_out(stim_out), .ref_out(ref_out), .bit_valid(bit_valid),
      .period_done(period_done), .busy(busy)
   );

   // Behavioural reference model
   bit m_pat[64];
   int m_wr = 0;
   bit m_run = 0;
   int m_phase = 0;
   int m_len = 1;
   bit m_pend = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_pat[i]) m_pat[i] = 1'b0;
         m_wr = 0; m_run = 0; m_phase = 0; m_len = 1; m_pend = 0;
      end else if (m_run) begin
         m_wr = 0;
         if (stop) m_pend = 1;
         if (bit_ce) begin
            if (m_phase == m_len - 1) begin
               m_phase = 0;
               if (m_pend) begin m_run = 0; m_pend = 0; end
            end else m_phase++;
         end
      end else begin
         if (load_en) begin
            m_pat[m_wr] = load_bit;
            m_wr = (m_wr + 1) % 64;
         end else m_wr = 0;
         if (start) begin
            m_run = 1; m_phase = 0; m_len = int'(len_m1) + 1; m_pend = 0;
         end
      end
   end

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
      end
   endtask

   // Per-cycle comparison, away from the clock edge
   always begin
      @(negedge clk);
      #5;
      if (!done) begin
         logic e_stim, e_valid, e_done;
         e_stim  = m_run ? m_pat[m_phase] : 1'b0;
         e_valid = m_run & bit_ce;
         e_done  = e_valid & (m_phase == m_len - 1);
         chk("R5", "stim_out", stim_out, e_stim);
         chk("R3", "ref_out", ref_out, e_stim);
         chk("R3", "bit_valid", bit_valid, e_valid);
         chk("R6", "period_done", period_done, e_done);
         chk("R8", "busy", busy, m_run);
         chk("R9", "path_out", path_out, test_mode ? e_stim : func_in);
      end
   end

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_pat(input logic [63:0] v, input int n);
      for (int k = 0; k < n; k++) begin
         load_en = 1'b1; load_bit = v[k];
         tick();
      end
      load_en = 1'b0; load_bit = 1'b0;
      tick();
   endtask

   task automatic pulse_start(input logic [5:0] l);
      len_m1 = l; start = 1'b1; tick(); start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 2000 && busy; k++) tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      #5;
      // R1 / R10: reset state at the ports
      chk("R1", "busy after reset", busy, 1'b0);
      chk("R1", "stim after reset", stim_out, 1'b0);
      chk("R10", "valid while idle", bit_valid, 1'b0);
      tick();

      // R2, R4, R5, R6: irregular 8-bit pattern, continuous rate; stop mid-pass (R8)
      load_pat(64'h4D, 8);
      pulse_start(6'd7);
      tick(21);
      stop = 1'b1; tick(); stop = 1'b0;
      wait_idle();
      tick(2);

      // Single-bit pattern: len_m1 = 0 (R4, R5, R6)
      load_pat(64'h1, 1);
      pulse_start(6'd0);
      tick(6);
      stop = 1'b1; tick(); stop = 1'b0;
      wait_idle();
      tick();

      // Full 64-bit pattern, bit_ce every third cycle (R7); disturbances while busy
      load_pat(64'hC3A5_0F1E_9B72_6D48, 64);
      pulse_start(6'd63);
      for (int k = 0; k < 600; k++) begin
         bit_ce    = (k % 3 == 0);
         func_in   = k[1];
         test_mode = (k % 50) < 35;                 // R9
         len_m1    = (k > 100) ? 6'd3 : 6'd63;      // R4: ignored while busy
         load_en   = (k > 200 && k < 230);          // R2: ignored while busy
         load_bit  = k[0];
         start     = (k == 300);                    // R8: ignored while busy
         tick();
      end
      load_en = 1'b0; start = 1'b0; bit_ce = 1'b1; test_mode = 1'b1;
      stop = 1'b1; tick(); stop = 1'b0;
      wait_idle();
      tick(2);

      // Replay without reload: stored bits must be unchanged (R2)
      pulse_start(6'd63);
      tick(140);
      stop = 1'b1; tick(); stop = 1'b0;
      wait_idle();
      tick(2);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule